// File: doc/BRIEF.md
# PLL Out-of-Lock Duration Monitor

This block watches the out-of-lock indication that a clock synthesizer raises. That indication is asynchronous to the monitor. The block brings it into the reference clock domain and counts how many consecutive reference cycles the condition has lasted. Once the count exceeds a programmable limit, the block raises a qualified out-of-lock flag. The limit is written as the required number of cycles minus one, so the smallest setting trips after a single cycle. The largest 16-bit setting trips after 65536 cycles, which is about 2 ms at a 32.768 MHz reference.

A select input chooses what the status output shows: either the synchronized raw indication or the time-qualified flag. When the qualified flag rises, the block emits a one-cycle pulse. That pulse sets a latched error bit, and only reset clears the bit. An enable input lets the surrounding logic hold off the qualification without hiding the raw condition.

Top module: `lock_watch`

## Requirements
- R1: The raw input passes through two flops. With select at 0, the status output goes high (low) two rising edges after the raw input goes high (low).
- R2: Let T be the threshold value. The qualified flag rises at the rising edge on which the synchronized raw signal has been sampled high for T+1 consecutive edges while enabled. It is not high at any earlier edge.
- R3: A threshold of 0x0000 trips after one sampled cycle. A threshold of 0xFFFF trips after exactly 65536 sampled cycles.
- R4: If the synchronized raw signal is sampled low on any edge, the count restarts from zero. A run shorter than T+1 never raises the flag.
- R5: The qualified flag clears on the first rising edge at which the synchronized raw signal is sampled low.
- R6: The duration count saturates rather than wrapping. The qualified flag stays high for as long as the raw condition persists, including beyond 131072 cycles.
- R7: A new threshold value applies at the very next edge and does not restart the count. Lowering the threshold below the current count trips the flag at the next edge.
- R8: While the enable input is low, the count is held at zero and the qualified flag is low. The status output in raw mode still follows the raw input.
- R9: The select input chooses the status source. A value of 0 shows the synchronized raw signal and a value of 1 shows the qualified flag.
- R10: The rise pulse output is high for exactly one cycle, in the cycle in which the qualified flag first becomes high.
- R11: The latched error output sets together with the rise pulse and stays set until reset.
- R12: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| ool_raw_i | input | 1 | Asynchronous raw out-of-lock indication |
| thresh_i | input | 16 | Threshold, required cycles minus one |
| enable_i | input | 1 | Enables duration qualification |
| mon_sel_i | input | 1 | Status source: 0 raw, 1 qualified |
| status_o | output | 1 | Selected out-of-lock status |
| qual_o | output | 1 | Qualified out-of-lock flag |
| qual_rise_o | output | 1 | One-cycle pulse when the qualified flag rises |
| err_seen_o | output | 1 | Latched error bit, cleared only by reset |

## Verification
The properties assume three things about the inputs:
- Reset is held low from time zero.
- Threshold, enable and select change synchronously to the reference clock.
- Only the raw indication arrives with arbitrary timing.

The bench drives every input, the raw indication included, on the falling clock edge. This makes the synchronizer latency an exact two edges, so flag timing can be predicted to the cycle. Threshold and enable changes are made in the middle of a raw run, to exercise their immediate effect while staying synchronous.

// File: rtl/lock_pkg.sv
package lock_pkg;

    // Status source selection
    typedef enum logic {
        MON_RAW  = 1'b0,
        MON_QUAL = 1'b1
    } mon_sel_e;

    // Default threshold width and synchronizer depth
    localparam int unsigned THR_W_DEF  = 16;
    localparam int unsigned SYNC_N_DEF = 2;

endpackage

// File: rtl/ool_sync.sv
// Multi-flop synchronizer for a single asynchronous level
module ool_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = (st_q.sh << 1) | STAGES'(d_async);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.sh[STAGES-1];
endmodule

// File: rtl/ool_dur_counter.sv
// Saturating persistence counter with live threshold compare
module ool_dur_counter #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] thresh,
    output logic [TW:0]   cnt,
    output logic          flag,
    output logic          flag_next
);
    localparam int unsigned CW = TW + 1;
    localparam logic [CW-1:0] CNT_MAX = {1'b1, {TW{1'b0}}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } dur_st_t;

    dur_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        st_d.flag = run && (st_d.cnt > {1'b0, thresh});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt       = st_q.cnt;
    assign flag      = st_q.flag;
    assign flag_next = st_d.flag;
endmodule

// File: rtl/ool_event.sv
// Rising-edge pulse and sticky error for the qualified flag
module ool_event (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_cur,
    input  logic flag_next,
    output logic rise,
    output logic seen
);
    typedef struct packed {
        logic rise;
        logic seen;
    } evt_st_t;

    evt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = flag_next && !flag_cur;
        st_d.seen = st_q.seen || st_d.rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.rise;
    assign seen = st_q.seen;
endmodule

// File: rtl/lock_watch.sv
module lock_watch
    import lock_pkg::*;
#(
    parameter int unsigned TW     = THR_W_DEF,
    parameter int unsigned SYNC_N = SYNC_N_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ool_raw_i,
    input  logic [TW-1:0] thresh_i,
    input  logic          enable_i,
    input  logic          mon_sel_i,
    output logic          status_o,
    output logic          qual_o,
    output logic          qual_rise_o,
    output logic          err_seen_o
);
    logic        raw_sync;
    logic [TW:0] dur_cnt;
    logic        qual_flag;
    logic        qual_next;
    logic        run;
    mon_sel_e    sel;

    ool_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ool_raw_i),
        .q       (raw_sync)
    );

    assign run = raw_sync && enable_i;

    ool_dur_counter #(.TW(TW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .thresh    (thresh_i),
        .cnt       (dur_cnt),
        .flag      (qual_flag),
        .flag_next (qual_next)
    );

    ool_event u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_cur  (qual_flag),
        .flag_next (qual_next),
        .rise      (qual_rise_o),
        .seen      (err_seen_o)
    );

    assign sel      = mon_sel_e'(mon_sel_i);
    assign status_o = (sel == MON_QUAL) ? qual_flag : raw_sync;
    assign qual_o   = qual_flag;
endmodule

// File: rtl/lock_watch_chk.sv
module lock_watch_chk #(
    parameter int unsigned TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [TW-1:0] thresh,
    input logic          raw_s,
    input logic [TW:0]   dur_cnt,
    input logic          qual_flag,
    input logic          qual_rise,
    input logic          err_seen
);
    localparam logic [TW:0] CNT_MAX = {1'b1, {TW{1'b0}}};

    p_trip_over_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_flag) |-> (dur_cnt > {1'b0, $past(thresh)}));

    p_clear_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_s |=> (dur_cnt == '0));

    p_flag_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_s |=> !qual_flag);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dur_cnt <= CNT_MAX);

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!qual_flag && dur_cnt == '0));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        qual_rise |=> !qual_rise);

    p_pulse_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        qual_rise |-> (qual_flag && !$past(qual_flag)));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen |=> err_seen);
endmodule

bind lock_watch lock_watch_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable_i),
    .thresh    (thresh_i),
    .raw_s     (raw_sync),
    .dur_cnt   (dur_cnt),
    .qual_flag (qual_flag),
    .qual_rise (qual_rise_o),
    .err_seen  (err_seen_o)
);

// File: tb/tb_lock_watch.sv
`timescale 1ns/1ps
module tb_lock_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw = 1'b0;
    logic [15:0] thr = 16'd0;
    logic        en = 1'b1;
    logic        msel = 1'b0;
    logic        status, qual, rise, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lock_watch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ool_raw_i   (raw),
        .thresh_i    (thr),
        .enable_i    (en),
        .mon_sel_i   (msel),
        .status_o    (status),
        .qual_o      (qual),
        .qual_rise_o (rise),
        .err_seen_o  (err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 180000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        raw = 1'b0;
        tick(4);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R12 status", status, 0);
        chk("R12 qual", qual, 0);
        chk("R12 rise", rise, 0);
        chk("R12 err", err, 0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_thr_zero();
        thr = 16'h0000; msel = 1'b1; en = 1'b1;
        raw = 1'b1;
        tick(2);
        chk("R3 min not yet", qual, 0);
        chk("R10 no early pulse", rise, 0);
        tick(1);
        chk("R3 min tripped", qual, 1);
        chk("R10 pulse", rise, 1);
        chk("R9 qual status", status, 1);
        chk("R11 err set", err, 1);
        tick(1);
        chk("R10 pulse one cycle", rise, 0);
        chk("R2 flag held", qual, 1);
        raw = 1'b0;
        tick(2);
        chk("R5 still high", qual, 1);
        tick(1);
        chk("R5 cleared", qual, 0);
        chk("R11 err kept", err, 1);
        quiet();
    endtask

    task automatic t_thr_five();
        thr = 16'd5; msel = 1'b1;
        raw = 1'b1;
        tick(7);
        chk("R2 T+2 low", qual, 0);
        tick(1);
        chk("R2 T+3 high", qual, 1);
        chk("R10 pulse T5", rise, 1);
        quiet();
    endtask

    task automatic t_restart();
        thr = 16'd5;
        raw = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            tick(1);
            chk("R4 short run", qual, 0);
        end
        raw = 1'b0;
        tick(1);
        raw = 1'b1;
        for (int i = 1; i <= 7; i++) begin
            tick(1);
            chk("R4 restarted count", qual, 0);
        end
        tick(1);
        chk("R4 trips after full run", qual, 1);
        quiet();
    endtask

    task automatic t_select();
        thr = 16'd50; msel = 1'b0;
        raw = 1'b1;
        tick(1);
        chk("R1 one edge", status, 0);
        tick(1);
        chk("R1 two edges", status, 1);
        msel = 1'b1;
        tick(1);
        chk("R9 qual source", status, 0);
        msel = 1'b0;
        tick(1);
        chk("R9 raw source", status, 1);
        raw = 1'b0;
        tick(1);
        chk("R1 fall one edge", status, 1);
        tick(1);
        chk("R1 fall two edges", status, 0);
        quiet();
    endtask

    task automatic t_enable();
        thr = 16'd3; msel = 1'b0; en = 1'b0;
        raw = 1'b1;
        tick(20);
        chk("R8 flag held low", qual, 0);
        chk("R8 raw status", status, 1);
        en = 1'b1;
        tick(3);
        chk("R8 count from zero", qual, 0);
        tick(1);
        chk("R8 trips after enable", qual, 1);
        quiet();
    endtask

    task automatic t_thr_change();
        thr = 16'd1000; msel = 1'b1;
        raw = 1'b1;
        tick(30);
        chk("R7 before change", qual, 0);
        thr = 16'd10;
        tick(1);
        chk("R7 lowered trips", qual, 1);
        thr = 16'hFFFF;
        tick(1);
        chk("R7 raised releases", qual, 0);
        thr = 16'd40;
        tick(10);
        chk("R7 no restart low", qual, 0);
        tick(1);
        chk("R7 no restart high", qual, 1);
        quiet();
    endtask

    task automatic t_max();
        thr = 16'hFFFF; msel = 1'b1;
        raw = 1'b1;
        tick(65537);
        chk("R3 max not yet", qual, 0);
        tick(1);
        chk("R3 max tripped", qual, 1);
        chk("R10 max pulse", rise, 1);
        tick(65600);
        chk("R6 saturated hold", qual, 1);
        quiet();
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0;
        tick(1);
        chk("R11 cleared by reset", err, 0);
        chk("R12 qual in reset", qual, 0);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        t_reset();
        t_thr_zero();
        t_thr_five();
        t_restart();
        t_select();
        t_enable();
        t_thr_change();
        t_max();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule